// File: doc/BRIEF.md
# Memory Pattern Fill-Verify Sequencer

This block is a hardware memory tester. After a start pulse it takes over a 32-bit synchronous memory port. It runs seven pattern passes over a memory region, always in the same order. In each pass it writes every word of the current window first. It then reads every word back and compares it with the value it wrote. The expected value is computed again from the pass number and the word index, so no copy of the written data is kept. The first mismatch stops the whole sequence. The block then reports the byte address, the expected word and the word that was read.

There are two coverage modes. Slow mode treats the whole region as one window. Normal mode covers only a thin slice at the bottom and at the top of each whole block of the region. The block size is 1 MiB by default and is set by a parameter. Any tail of the region shorter than a block is not tested in normal mode. Completion is shown by a one-cycle done pulse. The fail flag and its details stay valid until the next start.

Top module: `mem_pattern_sweep`

## Requirements
- R1: Within each window the passes run in this order, numbered 0 to 6: 0x00000000, 0xFFFFFFFF, 0x55555555, 0xAAAAAAAA, walking bit, word index, inverted word index. Passes 0 to 3 write the same constant to every word.
- R2: In each pass every word of the window is written, one word per cycle, in ascending address order. After the last write all words are read back in ascending order. Only one read is outstanding at any time. Its data is compared RD_LAT cycles after the read request.
- R3: At the first mismatch no further access is issued and no further pass is started. fail rises. fail_addr is the byte address of the failing read, fail_exp is the value written there and fail_got is the value read.
- R4: In normal mode, each whole block k of the region (size / 2^BLK_LOG2 blocks) gives two windows of WIN_BYTES bytes each. They are taken in this order: first at region_base + k·2^BLK_LOG2, then at region_base + (k+1)·2^BLK_LOG2 − WIN_BYTES. All seven passes finish on one window before the next window starts.
- R5: In slow mode there is one window. It starts at region_base and holds floor(region_size / 4) words.
- R6: The word index i counts from 0 at the start of each window. Pass 4 writes 1 << (i mod 32). Pass 5 writes i, zero-extended to 32 bits. Pass 6 writes the bitwise inverse of that value.
- R7: In normal mode any part of the size beyond the last whole block is not accessed. If there is no whole block (normal mode), or no whole word (slow mode), done is given with fail low and no memory access is made.
- R8: After reset, busy, done, fail and mem_req are all low. In the cycle after an accepted start, fail is low and busy is high whenever there is work. done is high for exactly one cycle after the final compare. fail and its details hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run; taken only when idle |
| slow_mode | input | 1 | 1: whole region; 0: boundary windows |
| region_base | input | ADDR_W | Byte address of region start, block aligned |
| region_size | input | ADDR_W | Region size in bytes |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid RD_LAT cycles after a read request |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | A mismatch was found |
| fail_addr | output | ADDR_W | Byte address of the mismatch |
| fail_exp | output | 32 | Expected word |
| fail_got | output | 32 | Word read |

## Verification
A mismatch and the end of the whole sequence can happen in the same cycle. This is the case when the very last read of the last pass of the last window is corrupted. The bench sets this up by flipping bits in the read data of exactly that read. It then checks three things: done still pulses once, fail is set, and the reported address and values belong to that last word and not to an earlier one. A persistent fault that swaps two data bits at one word is also injected. Those two bits agree in every constant pattern, so the failure must first show up in the word-index pass. This checks that the passes run in order and stop at the first mismatch.

// File: rtl/msq_pkg.sv
package msq_pkg;
   typedef enum logic [2:0] {
      P_ZERO = 3'd0,
      P_ONES = 3'd1,
      P_ODD  = 3'd2,
      P_EVEN = 3'd3,
      P_WALK = 3'd4,
      P_IDX  = 3'd5,
      P_NIDX = 3'd6
   } pass_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_WR   = 2'd1,
      S_RD   = 2'd2,
      S_DONE = 2'd3
   } seq_state_e;
endpackage

// File: rtl/msq_pattern_gen.sv
module msq_pattern_gen
   import msq_pkg::*;
#(
   parameter int unsigned IW = 8
) (
   input  pass_e          pass_i,
   input  logic [IW-1:0]  idx_i,
   output logic [31:0]    val_o
);
   generate
      if (IW < 5 || IW > 32) begin : g_bad_iw
         $error("msq_pattern_gen: IW must lie in 5..32");
      end
   endgenerate

   logic [31:0] idx32;
   assign idx32 = 32'(idx_i);

   always_comb begin
      unique case (pass_i)
         P_ZERO:  val_o = 32'h0000_0000;
         P_ONES:  val_o = 32'hFFFF_FFFF;
         P_ODD:   val_o = 32'h5555_5555;
         P_EVEN:  val_o = 32'hAAAA_AAAA;
         P_WALK:  val_o = 32'd1 << idx_i[4:0];
         P_IDX:   val_o = idx32;
         P_NIDX:  val_o = ~idx32;
         default: val_o = 32'h0000_0000;
      endcase
   end
endmodule

// File: rtl/msq_rd_pipe.sv
module msq_rd_pipe #(
   parameter int unsigned LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_i,
   output logic out_o
);
   generate
      if (LAT == 0) begin : g_bad_lat
         $error("msq_rd_pipe: LAT must be at least 1");
      end else if (LAT == 1) begin : g_one
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= in_i;
         end
         assign out_o = q;
      end else begin : g_chain
         logic [LAT-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= {q[LAT-2:0], in_i};
         end
         assign out_o = q[LAT-1];
      end
   endgenerate
endmodule

// File: rtl/mem_pattern_sweep.sv
module mem_pattern_sweep
   import msq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned RD_LAT    = 1,
   parameter int unsigned BLK_LOG2  = 20,
   parameter int unsigned WIN_BYTES = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              slow_mode,
   input  logic [ADDR_W-1:0] region_base,
   input  logic [ADDR_W-1:0] region_size,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [31:0]       fail_exp,
   output logic [31:0]       fail_got
);
   localparam int unsigned IW        = ADDR_W - 2;
   localparam int unsigned KW        = ADDR_W - BLK_LOG2;
   localparam int unsigned BLK_BYTES = 1 << BLK_LOG2;
   localparam int unsigned WIN_WORDS = WIN_BYTES / 4;

   generate
      if (BLK_LOG2 >= ADDR_W) begin : g_bad_blk
         $error("mem_pattern_sweep: block must be smaller than address space");
      end
      if (WIN_BYTES % 4 != 0 || WIN_BYTES == 0) begin : g_bad_win_align
         $error("mem_pattern_sweep: window must be a nonzero word multiple");
      end
      if (2 * WIN_BYTES > BLK_BYTES) begin : g_bad_win_size
         $error("mem_pattern_sweep: two windows must fit in one block");
      end
   endgenerate

   seq_state_e        st_q;
   pass_e             pass_q;
   logic [IW-1:0]     idx_q, last_idx_q;
   logic [ADDR_W-1:0] base_q, size_q, win_base_q;
   logic [KW-1:0]     blk_q, last_blk_q;
   logic              slow_q, half_q, pend_q;
   logic              rd_back;
   logic [31:0]       pat;

   logic [IW-1:0]     words_slow;
   logic [KW-1:0]     nblk;
   assign words_slow = region_size[ADDR_W-1:2];
   assign nblk       = region_size[ADDR_W-1:BLK_LOG2];

   msq_pattern_gen #(.IW(IW)) u_pat (
      .pass_i (pass_q),
      .idx_i  (idx_q),
      .val_o  (pat)
   );

   logic rd_issue;
   assign rd_issue = (st_q == S_RD) && !pend_q;

   msq_rd_pipe #(.LAT(RD_LAT)) u_rdp (
      .clk   (clk),
      .rst_n (rst_n),
      .in_i  (rd_issue),
      .out_o (rd_back)
   );

   assign mem_req   = (st_q == S_WR) || rd_issue;
   assign mem_we    = (st_q == S_WR);
   assign mem_addr  = win_base_q + {idx_q, 2'b00};
   assign mem_wdata = pat;
   assign busy      = (st_q == S_WR) || (st_q == S_RD);
   assign done      = (st_q == S_DONE);

   logic [ADDR_W-1:0] blk_off, next_blk_off;
   assign blk_off      = ADDR_W'(blk_q) << BLK_LOG2;
   assign next_blk_off = ADDR_W'(blk_q + KW'(1)) << BLK_LOG2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         pass_q     <= P_ZERO;
         idx_q      <= '0;
         last_idx_q <= '0;
         base_q     <= '0;
         size_q     <= '0;
         win_base_q <= '0;
         blk_q      <= '0;
         last_blk_q <= '0;
         slow_q     <= 1'b0;
         half_q     <= 1'b0;
         pend_q     <= 1'b0;
         fail       <= 1'b0;
         fail_addr  <= '0;
         fail_exp   <= '0;
         fail_got   <= '0;
      end else begin
         unique case (st_q)
            S_IDLE: if (start) begin
               fail       <= 1'b0;
               pass_q     <= P_ZERO;
               idx_q      <= '0;
               base_q     <= region_base;
               size_q     <= region_size;
               win_base_q <= region_base;
               slow_q     <= slow_mode;
               half_q     <= 1'b0;
               blk_q      <= '0;
               pend_q     <= 1'b0;
               if (slow_mode) begin
                  last_idx_q <= words_slow - IW'(1);
                  st_q       <= (words_slow == '0) ? S_DONE : S_WR;
               end else begin
                  last_idx_q <= IW'(WIN_WORDS - 1);
                  last_blk_q <= nblk - KW'(1);
                  st_q       <= (nblk == '0) ? S_DONE : S_WR;
               end
            end
            S_WR: begin
               if (idx_q == last_idx_q) begin
                  idx_q <= '0;
                  st_q  <= S_RD;
               end else begin
                  idx_q <= idx_q + IW'(1);
               end
            end
            S_RD: begin
               if (rd_issue) pend_q <= 1'b1;
               if (rd_back) begin
                  pend_q <= 1'b0;
                  if (mem_rdata != pat) begin
                     fail      <= 1'b1;
                     fail_addr <= mem_addr;
                     fail_exp  <= pat;
                     fail_got  <= mem_rdata;
                     st_q      <= S_DONE;
                  end else if (idx_q != last_idx_q) begin
                     idx_q <= idx_q + IW'(1);
                  end else begin
                     idx_q <= '0;
                     if (pass_q != P_NIDX) begin
                        pass_q <= pass_e'(pass_q + 3'd1);
                        st_q   <= S_WR;
                     end else begin
                        pass_q <= P_ZERO;
                        if (slow_q) begin
                           st_q <= S_DONE;
                        end else if (!half_q) begin
                           half_q     <= 1'b1;
                           win_base_q <= base_q + blk_off + ADDR_W'(BLK_BYTES - WIN_BYTES);
                           st_q       <= S_WR;
                        end else if (blk_q == last_blk_q) begin
                           st_q <= S_DONE;
                        end else begin
                           half_q     <= 1'b0;
                           blk_q      <= blk_q + KW'(1);
                           win_base_q <= base_q + next_blk_off;
                           st_q       <= S_WR;
                        end
                     end
                  end
               end
            end
            S_DONE: st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   // R8: completion is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: a read request is never followed directly by another read request
   a_r2_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> !(mem_req && !mem_we));

   // R3: the fail report holds until a new start arrives
   a_r3_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> (fail && $stable(fail_addr) && $stable(fail_got)));

   // R3: no memory traffic once a mismatch is recorded
   a_r3_quiet_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> !mem_req);

   // R4, R5, R7: every access stays inside the requested region
   a_r4_addr_in_region: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_addr - base_q) < size_q));

   // R8: no access while not busy
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);
endmodule

// File: tb/tb_mem_pattern_sweep.sv
module tb_mem_pattern_sweep;
   localparam int CLK_NS = 10;
   localparam int AW     = 11;
   localparam int LAT    = 2;
   localparam int BLK_L2 = 6;
   localparam int BLK    = 1 << BLK_L2;
   localparam int WIN    = 16;
   localparam int NWORDS = 1 << (AW - 2);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          slow_mode = 1'b0;
   logic [AW-1:0] region_base = '0;
   logic [AW-1:0] region_size = '0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata, mem_rdata;
   logic          busy, done, fail;
   logic [AW-1:0] fail_addr;
   logic [31:0]   fail_exp, fail_got;

   always #(CLK_NS/2) clk = ~clk;

   mem_pattern_sweep #(.ADDR_W(AW), .RD_LAT(LAT), .BLK_LOG2(BLK_L2), .WIN_BYTES(WIN)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .slow_mode(slow_mode),
      .region_base(region_base), .region_size(region_size),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
      .fail_exp(fail_exp), .fail_got(fail_got));

   // fault controls
   bit        swap_en  = 0;
   int        swap_word = -1;
   int        rx_n     = 0;
   logic [31:0] rx_mask = 32'h0;

   function automatic logic [31:0] swapf(int w, logic [31:0] d);
      logic [31:0] r;
      r = d;
      if (swap_en && w == swap_word) begin
         r[1] = d[3];
         r[3] = d[1];
      end
      return r;
   endfunction

   // bench memory model with LAT-cycle read data
   logic [31:0] mem [NWORDS];
   logic [31:0] rp  [LAT];
   int          rd_cnt = 0;
   assign mem_rdata = rp[LAT-1];

   always @(posedge clk) begin
      if (mem_req && mem_we)
         mem[int'(mem_addr[AW-1:2])] <= swapf(int'(mem_addr[AW-1:2]), mem_wdata);
      if (mem_req && !mem_we) begin
         rp[0]  <= mem[int'(mem_addr[AW-1:2])] ^ (((rd_cnt + 1) == rx_n) ? rx_mask : 32'h0);
         rd_cnt <= rd_cnt + 1;
      end else begin
         rp[0] <= 32'h0;
      end
      for (int k = 1; k < LAT; k++) rp[k] <= rp[k-1];
      if (start) rd_cnt <= 0;
   end

   function automatic logic [31:0] pat(int p, int i);
      case (p)
         0: return 32'h0000_0000;
         1: return 32'hFFFF_FFFF;
         2: return 32'h5555_5555;
         3: return 32'hAAAA_AAAA;
         4: return 32'd1 << (i % 32);
         5: return 32'(i);
         default: return ~32'(i);
      endcase
   endfunction

   // expected access list
   bit          ew[$];
   int          ea[$];
   logic [31:0] ed[$];
   bit          x_fail;
   int          x_addr;
   logic [31:0] x_exp, x_got;

   task automatic plan(bit slow, int base, int size);
      int wb[$];
      int words;
      int rdn;
      ew.delete(); ea.delete(); ed.delete();
      x_fail = 0; x_addr = 0; x_exp = 0; x_got = 0; rdn = 0;
      if (slow) begin
         words = size / 4;
         if (words > 0) wb.push_back(base);
      end else begin
         words = WIN / 4;
         for (int k = 0; k < size / BLK; k++) begin
            wb.push_back(base + k * BLK);
            wb.push_back(base + (k + 1) * BLK - WIN);
         end
      end
      foreach (wb[w]) begin
         for (int p = 0; p < 7; p++) begin
            for (int i = 0; i < words; i++) begin
               ew.push_back(1); ea.push_back(wb[w] + 4 * i); ed.push_back(pat(p, i));
            end
            for (int i = 0; i < words; i++) begin
               logic [31:0] g;
               rdn++;
               ew.push_back(0); ea.push_back(wb[w] + 4 * i); ed.push_back(32'h0);
               g = swapf((wb[w] + 4 * i) / 4, pat(p, i)) ^ ((rdn == rx_n) ? rx_mask : 32'h0);
               if (g != pat(p, i)) begin
                  x_fail = 1; x_addr = wb[w] + 4 * i; x_exp = pat(p, i); x_got = g;
                  return;
               end
            end
         end
      end
   endtask

   // access monitor
   int  qpos = 0;
   int  mis  = 0;
   string mis_msg = "";

   always @(negedge clk) begin
      if (rst_n && mem_req) begin
         if (qpos >= ew.size()) begin
            if (mis == 0) $sformat(mis_msg, "extra access addr=%0h we=%0d", mem_addr, mem_we);
            mis++;
         end else if (mem_we != ew[qpos] || int'(mem_addr) != ea[qpos] ||
                      (mem_we && mem_wdata != ed[qpos])) begin
            if (mis == 0) $sformat(mis_msg, "access %0d: got we=%0d addr=%0h data=%08h, expected we=%0d addr=%0h data=%08h",
                                   qpos, mem_we, mem_addr, mem_wdata, ew[qpos], ea[qpos], ed[qpos]);
            mis++;
         end
         qpos++;
      end
   end

   int total = 0;
   int bad   = 0;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_case(string tag, bit slow, int base, int size);
      int n;
      int dcnt;
      bit seen;
      plan(slow, base, size);
      qpos = 0; mis = 0; mis_msg = "";
      @(negedge clk);
      slow_mode = slow; region_base = AW'(base); region_size = AW'(size); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(fail == 1'b0, "R8", {tag, " fail cleared after start"}, fail, 0);
      chk(busy == (ew.size() > 0), "R8", {tag, " busy after start"}, busy, ew.size() > 0);
      n = 0; dcnt = 0; seen = 0;
      while (!seen && n < 30000) begin
         if (done) begin seen = 1; dcnt++; end
         else begin @(negedge clk); n++; end
      end
      chk(seen, "R8", {tag, " done seen (watchdog)"}, seen, 1);
      @(negedge clk);
      if (done) dcnt++;
      chk(dcnt == 1, "R8", {tag, " done width"}, dcnt, 1);
      chk(mis == 0, tag, {" access order ", mis_msg}, mis, 0);
      chk(qpos == ew.size(), tag, " access count", qpos, ew.size());
      chk(fail == x_fail, "R3", {tag, " fail flag"}, fail, x_fail);
      if (x_fail) begin
         chk(int'(fail_addr) == x_addr, "R3", {tag, " fail_addr"}, fail_addr, x_addr);
         chk(fail_exp == x_exp, "R3", {tag, " fail_exp"}, fail_exp, x_exp);
         chk(fail_got == x_got, "R3", {tag, " fail_got"}, fail_got, x_got);
      end
      repeat (5) @(negedge clk);
      chk(fail == x_fail && busy == 1'b0, "R8", {tag, " result held"}, fail, x_fail);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !fail && !mem_req, "R8", "reset state", {busy, done, fail, mem_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // slow sweep over 256 words: pass order, walking-bit wrap, index patterns
      run_case("R1 R2 R5 R6 slow-full", 1, 0, 1024);
      // normal mode, three whole blocks plus a tail that must be skipped
      run_case("R4 R7 normal-tail", 0, 0, 3 * BLK + 20);
      // slow, odd size not a word multiple
      run_case("R5 slow-odd", 1, 512, 46);
      // persistent bit swap on word 2: constants and walking pass, index pass fails
      swap_en = 1; swap_word = (512 + 8) / 4;
      run_case("R3 R1 swap-fault", 1, 512, 256);
      swap_en = 0;
      // corrupt the very last read of the last window: fail and end together
      rx_n = 4 * 7 * (WIN / 4); rx_mask = 32'h8000_0001;
      run_case("R3 R4 last-read-fault", 0, 0, 2 * BLK);
      // corrupt the first read
      rx_n = 1; rx_mask = 32'h0000_0100;
      run_case("R3 first-read-fault", 1, 128, 64);
      rx_n = 0; rx_mask = 32'h0;
      // normal mode below one block: immediate done, no traffic
      run_case("R7 normal-empty", 0, 0, 40);
      // slow mode below one word
      run_case("R7 slow-empty", 1, 64, 3);
      // a clean run after a failure clears the report
      run_case("R8 R4 rerun", 0, 256, 2 * BLK);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule